// File: doc/BRIEF.md
# Dual Periodic Interrupt Generator

This block raises two periodic interrupt requests from one shared free-running divider. A source selector feeds the divider with one of three tick rates, all expressed as clock-enable pulses in the single system clock domain: every system clock cycle, one system cycle in four, or an externally supplied slow tick. The divider is a 16-bit counter that advances on each source tick. Channel 0 draws its period from the lower eight power-of-two taps and channel 1 from the upper eight, so the two channels never share a period.

Each channel latches a pending flag when its selected tap completes a period, provided the channel is switched on. A request towards the core is raised when the global enable is set, the call stack is not full and at least one switched-on channel is pending. Channel 0 wins when both are pending. When the core accepts the request, the flag of the served channel and the global enable are both cleared, so no further request is raised until the enable is set again.

Top module: `tbase_irq_gen`

## Requirements
- R1: `src_sel_i` picks the divider tick: 0 = every clock cycle, 1 = one cycle in four, 2 and 3 = each cycle where `sub_tick_i` is high.
- R2: With channel 0 on and `tb0_sel_i` = n, its flag is set once every 2^n divider ticks.
- R3: With channel 1 on and `tb1_sel_i` = n, its flag is set once every 2^(8+n) divider ticks.
- R4: While a channel's on input is low its flag is never set; the shared divider keeps counting.
- R5: `vec_req_o` is high exactly when `gie_o` is high, `stack_full_i` is low and some channel has both its flag and its on input set; `vec_id_o` names that channel.
- R6: A set flag stays set until its channel is served.
- R7: A service is `ack_i` high while `vec_req_o` is high; it clears the served channel's flag and `gie_o` on the next clock. `gie_set_i` sets `gie_o`, but a service in the same cycle wins.
- R8: When both channels are pending and enabled, `vec_id_o` is 0.
- R9: After reset all flags, `gie_o` and `vec_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Divider tick source select |
| sub_tick_i | input | 1 | Slow clock tick, one cycle wide |
| tb0_sel_i | input | 3 | Channel 0 tap select (2^0..2^7) |
| tb1_sel_i | input | 3 | Channel 1 tap select (2^8..2^15) |
| tb0_on_i | input | 1 | Channel 0 enable |
| tb1_on_i | input | 1 | Channel 1 enable |
| stack_full_i | input | 1 | Core call stack is full |
| gie_set_i | input | 1 | Set global interrupt enable |
| ack_i | input | 1 | Core accepts the current request |
| vec_req_o | output | 1 | Interrupt vector request |
| vec_id_o | output | 1 | Channel of the current request |
| gie_o | output | 1 | Global interrupt enable state |
| flag_o | output | 2 | Pending flags, bit i for channel i |

## Verification
The assertions watch every cycle for the request gating against enable, stack-full and pending flags, the priority of channel 0, flags that never rise while a channel is off, flags that hold until served, and the enable being dropped after each service. The interrupt periods themselves, across all source selections and both tap ranges, can only be shown by the bench's scenarios, which time successive services and compare each interval with the period derived from the source rate and tap. The bench also drives the enable set colliding with a service and the stack-full hold-off with both flags pending.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [1:0] {
    SRC_SYS      = 2'd0,
    SRC_SYS_DIV4 = 2'd1,
    SRC_SUB      = 2'd2,
    SRC_SUB_ALT  = 2'd3
  } src_sel_e;

  localparam int unsigned CNT_W = 16;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/tbase_src_mux.sv
module tbase_src_mux #(
  parameter int unsigned DIV_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] src_sel_i,
  input  logic       sub_tick_i,
  output logic       src_en_o
);
  import tbase_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic             div_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign div_tick = &div_q;

  always_comb begin
    unique case (src_sel_e'(src_sel_i))
      SRC_SYS:      src_en_o = 1'b1;
      SRC_SYS_DIV4: src_en_o = div_tick;
      default:      src_en_o = sub_tick_i;
    endcase
  end
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_en_i,
  output logic [CNT_W-1:0] ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (src_en_i) cnt_q <= cnt_q + 1'b1;
  end

  // ovf_o[n]: carry out of the low n bits, one pulse per 2^n ticks
  for (genvar n = 0; n < CNT_W; n++) begin : g_ovf
    if (n == 0) begin : g_base
      assign ovf_o[n] = src_en_i;
    end else begin : g_carry
      assign ovf_o[n] = src_en_i & (&cnt_q[n-1:0]);
    end
  end
endmodule

// File: rtl/tbase_chan.sv
module tbase_chan #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned BASE  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ovf_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             on_i,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam int unsigned IDX_W = $clog2(CNT_W);

  logic [IDX_W-1:0] tap_idx;
  logic             set;

  assign tap_idx = IDX_W'(BASE) + IDX_W'(sel_i);
  assign set     = on_i & ovf_i[tap_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/tbase_arb.sv
module tbase_arb #(
  parameter int unsigned N_CH = 2,
  localparam int unsigned ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] flag_i,
  input  logic [N_CH-1:0] on_i,
  input  logic            stack_full_i,
  input  logic            gie_set_i,
  input  logic            ack_i,
  output logic            vec_req_o,
  output logic [ID_W-1:0] vec_id_o,
  output logic [N_CH-1:0] clr_o,
  output logic            gie_o
);
  logic [N_CH-1:0] pend;
  logic            svc;

  assign pend      = flag_i & on_i;
  assign vec_req_o = gie_o & ~stack_full_i & (|pend);
  assign svc       = vec_req_o & ack_i;

  // lowest index wins
  always_comb begin
    vec_id_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend[i]) vec_id_o = ID_W'(i);
    end
  end

  always_comb begin
    clr_o = '0;
    if (svc) clr_o[vec_id_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gie_o <= 1'b0;
    else if (svc)       gie_o <= 1'b0;
    else if (gie_set_i) gie_o <= 1'b1;
  end
endmodule

// File: rtl/tbase_irq_gen.sv
module tbase_irq_gen
  import tbase_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] src_sel_i,
  input  logic       sub_tick_i,
  input  logic [2:0] tb0_sel_i,
  input  logic [2:0] tb1_sel_i,
  input  logic       tb0_on_i,
  input  logic       tb1_on_i,
  input  logic       stack_full_i,
  input  logic       gie_set_i,
  input  logic       ack_i,
  output logic       vec_req_o,
  output logic       vec_id_o,
  output logic       gie_o,
  output logic [1:0] flag_o
);
  logic             src_en;
  logic [CNT_W-1:0] ovf;
  logic [N_CH-1:0]  on_vec;
  logic [N_CH-1:0]  clr;
  logic [SEL_W-1:0] sel_vec [N_CH];

  assign on_vec     = {tb1_on_i, tb0_on_i};
  assign sel_vec[0] = tb0_sel_i;
  assign sel_vec[1] = tb1_sel_i;

  tbase_src_mux #(.DIV_W(2)) u_src (
    .clk_i, .rst_ni, .src_sel_i, .sub_tick_i, .src_en_o(src_en)
  );

  tbase_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk_i, .rst_ni, .src_en_i(src_en), .ovf_o(ovf)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tbase_chan #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .BASE(c * (2 ** SEL_W))
    ) u_ch (
      .clk_i, .rst_ni,
      .ovf_i (ovf),
      .sel_i (sel_vec[c]),
      .on_i  (on_vec[c]),
      .clr_i (clr[c]),
      .flag_o(flag_o[c])
    );
  end

  tbase_arb #(.N_CH(N_CH)) u_arb (
    .clk_i, .rst_ni,
    .flag_i      (flag_o),
    .on_i        (on_vec),
    .stack_full_i,
    .gie_set_i,
    .ack_i,
    .vec_req_o,
    .vec_id_o,
    .clr_o       (clr),
    .gie_o
  );
endmodule

// File: rtl/tbase_irq_gen_chk.sv
module tbase_irq_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stack_full_i,
  input logic       ack_i,
  input logic       tb0_on_i,
  input logic       tb1_on_i,
  input logic       vec_req_o,
  input logic       vec_id_o,
  input logic       gie_o,
  input logic [1:0] flag_o
);
  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> (gie_o && !stack_full_i &&
                   (vec_id_o ? (flag_o[1] && tb1_on_i) : (flag_o[0] && tb0_on_i)))); // R5

  AST_CH0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && flag_o[0] && tb0_on_i) |-> !vec_id_o); // R8

  AST_OFF0_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tb0_on_i |=> !$rose(flag_o[0])); // R4

  AST_OFF1_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tb1_on_i |=> !$rose(flag_o[1])); // R4

  AST_FLAG0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && !(vec_req_o && ack_i && !vec_id_o)) |=> flag_o[0]); // R6

  AST_FLAG1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[1] && !(vec_req_o && ack_i && vec_id_o)) |=> flag_o[1]); // R6

  AST_SVC_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && ack_i) |=> !gie_o); // R7
endmodule

bind tbase_irq_gen tbase_irq_gen_chk u_chk (.*);

// File: tb/tbase_irq_gen_tb_top.sv
module tbase_irq_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] src_sel_i = 2'd0;
  logic       sub_tick_i = 1'b0;
  logic [2:0] tb0_sel_i = 3'd0;
  logic [2:0] tb1_sel_i = 3'd0;
  logic       tb0_on_i = 1'b0;
  logic       tb1_on_i = 1'b0;
  logic       stack_full_i = 1'b0;
  logic       gie_set_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       vec_req_o;
  logic       vec_id_o;
  logic       gie_o;
  logic [1:0] flag_o;

  tbase_irq_gen dut_i (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    int    interval;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   sub_period = 0;
  int   sub_cnt = 0;
  bit   mon_en = 0;
  int   mon_ch = 0;
  int   skip = 0;
  int   last_t = 0;
  bit   done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (sub_period > 0) begin
      if (sub_cnt >= sub_period - 1) begin
        sub_cnt    = 0;
        sub_tick_i = 1'b1;
      end else begin
        sub_cnt++;
        sub_tick_i = 1'b0;
      end
    end else begin
      sub_tick_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: time successive services of the watched channel
  always @(negedge clk_i) begin
    if (mon_en && vec_req_o && ack_i) begin
      chk(int'(vec_id_o) == mon_ch, "R5 id", int'(vec_id_o), mon_ch);
      if (skip > 0) begin
        skip--;
        last_t = cyc;
      end else if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(cyc - last_t == e.interval, e.req, cyc - last_t, e.interval);
        last_t = cyc;
      end
    end
  end

  // driver: configure one channel and push expected service intervals
  task automatic run_period(input int src, input int subp, input int ch,
                            input int sel, input int period, input int n,
                            input string req);
    int guard;
    @(negedge clk_i);
    #1;
    src_sel_i  = 2'(src);
    sub_period = subp;
    sub_cnt    = 0;
    tb0_sel_i  = 3'(sel);
    tb1_sel_i  = 3'(sel);
    tb0_on_i   = (ch == 0);
    tb1_on_i   = (ch == 1);
    mon_ch     = ch;
    skip       = 2;
    for (int i = 0; i < n; i++) q.push_back('{period, req});
    mon_en = 1;
    guard = 0;
    while (q.size() > 0 && guard < period * (n + 4) + 64) begin
      @(negedge clk_i);
      guard++;
    end
    chk(q.size() == 0, req, q.size(), 0);
    q.delete();
    #1;
    mon_en = 0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(flag_o == 2'b00, "R9 flags", flag_o, 0);
    chk(gie_o == 1'b0, "R9 gie", gie_o, 0);
    chk(vec_req_o == 1'b0, "R9 req", vec_req_o, 0);

    // channel 1 off while divider runs past its tap
    tb0_on_i = 1'b1;
    cycles(600);
    chk(flag_o[0] == 1'b1, "R6 flag0 held", flag_o[0], 1);
    chk(flag_o[1] == 1'b0, "R4 flag1 off", flag_o[1], 0);
    chk(vec_req_o == 1'b0, "R5 no gie", vec_req_o, 0);
    tb1_on_i = 1'b1;
    cycles(300);
    chk(flag_o[1] == 1'b1, "R4 divider kept running", flag_o[1], 1);

    // freeze the source so flags only change by service
    src_sel_i = 2'd2;
    cycles(2);
    stack_full_i = 1'b1;
    gie_set_i    = 1'b1;
    cycles(1);
    gie_set_i    = 1'b0;
    chk(gie_o == 1'b1, "R7 gie set", gie_o, 1);
    chk(vec_req_o == 1'b0, "R5 stack full", vec_req_o, 0);
    stack_full_i = 1'b0;
    #1;
    chk(vec_req_o == 1'b1, "R5 req", vec_req_o, 1);
    chk(vec_id_o == 1'b0, "R8 ch0 first", vec_id_o, 0);
    cycles(1);
    ack_i = 1'b1;
    cycles(1);
    ack_i = 1'b0;
    chk(flag_o == 2'b10, "R7 flag0 cleared", flag_o, 2);
    chk(gie_o == 1'b0, "R7 gie cleared", gie_o, 0);
    chk(vec_req_o == 1'b0, "R5 req after svc", vec_req_o, 0);
    cycles(20);
    chk(flag_o[1] == 1'b1, "R6 flag1 held", flag_o[1], 1);
    gie_set_i = 1'b1;
    cycles(1);
    gie_set_i = 1'b0;
    chk(vec_req_o == 1'b1 && vec_id_o == 1'b1, "R5 ch1 req", {vec_req_o, vec_id_o}, 3);
    gie_set_i = 1'b1;
    ack_i     = 1'b1;
    cycles(1);
    gie_set_i = 1'b0;
    ack_i     = 1'b0;
    chk(gie_o == 1'b0, "R7 service beats set", gie_o, 0);
    chk(flag_o == 2'b00, "R7 flag1 cleared", flag_o, 0);

    // periodic services: set and ack held, one channel at a time
    gie_set_i = 1'b1;
    ack_i     = 1'b1;
    run_period(0, 0, 0, 2, 4,    3, "R2 sys /4");
    run_period(0, 0, 0, 7, 128,  3, "R2 sys /128");
    run_period(1, 0, 0, 3, 32,   3, "R1 sys4 /8");
    run_period(2, 3, 0, 2, 12,   3, "R1 sub /4");
    run_period(3, 3, 0, 0, 3,    3, "R1 sub alt /1");
    run_period(0, 0, 1, 0, 256,  3, "R3 sys /256");
    run_period(0, 0, 1, 2, 1024, 3, "R3 sys /1024");
    run_period(1, 0, 1, 0, 1024, 2, "R3 sys4 /256");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule